// File: doc/BRIEF.md
# Four-Position Lookahead Carry Generator

This combinational unit resolves the carries inside a group of four adjacent positions in one step. It takes one generate bit and one propagate bit for each position, plus the carry entering the group. It returns the three carries that enter positions 1, 2 and 3 of the group. Each of them is a flat sum of products rather than a chain, so every output sits two gate levels behind the inputs.

The unit does not return the carry that leaves the group. Instead it condenses the whole group into one generate bit and one propagate bit. A second unit of the same kind, one tree level up, takes those two bits and forms the carry into the next group. The generate and propagate inputs may be per-bit signals from operand logic, or group signals from a lower level of the tree. The unit treats both cases alike. Forming the per-bit signals and forming the sums belong to neighbouring logic.

Top module: `lcg4_carry_gen`

## Requirements
- R1: carry_mid_o[0], the carry into position 1, equals gen_i[0] OR (carry_i AND prop_i[0]). Bit k of gen_i and prop_i belongs to position k.
- R2: carry_mid_o[1], the carry into position 2, equals gen_i[1] OR (gen_i[0] AND prop_i[1]) OR (carry_i AND prop_i[0] AND prop_i[1]).
- R3: carry_mid_o[2], the carry into position 3, equals the ripple recurrence c(k+1) = gen_i[k] OR (c(k) AND prop_i[k]) taken from c(0) = carry_i.
- R4: grp_gen_o is high exactly when position 3 generates, or when a lower position generates and every position above it propagates. It does not depend on carry_i.
- R5: grp_prop_o is high exactly when all four prop_i bits are high. When it is high and no gen_i bit is set, every carry_mid_o bit equals carry_i.
- R6: grp_gen_o OR (carry_i AND grp_prop_o) equals the ripple carry out of position 3, for every input combination.
- R7: The unit holds no state. With all inputs low, every output is low, and each output follows the present inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gen_i | input | 4 | Generate bit per position (bit k = position k) |
| prop_i | input | 4 | Propagate bit per position (bit k = position k) |
| carry_i | input | 1 | Carry entering position 0 |
| carry_mid_o | output | 3 | Carries into positions 1..3 (bit k-1 = into position k) |
| grp_gen_o | output | 1 | Group generate across all four positions |
| grp_prop_o | output | 1 | Group propagate across all four positions |

## Verification
The internal carries and the group generate can all respond to one event in the same cycle. A generate at position 0, with every higher position propagating, raises all three internal carries and the group generate together. An incoming carry with all propagates set does the same through grp_prop_o. The bench applies every one of the 512 combinations of the nine inputs, so every such overlap occurs. Each output is compared against a ripple-recurrence model of the bench, and the carry out rebuilt from the group pair is compared against the ripple carry out of position 3.

// File: rtl/lcg4_pkg.sv
// Package: shared sizing for the lookahead carry generator.
// Assumes: a group spans a small fixed number of positions (default four).
package lcg4_pkg;
    localparam int unsigned GROUP_W = 4;
    localparam int unsigned MID_W   = GROUP_W - 1;
endpackage

// File: rtl/lcg4_sop.sv
// Module: lcg4_sop
// Forms a flat sum of products across N positions:
//   out = seed & P[N-1:0]  |  OR_j ( gen[j] & P[N-1:j+1] )
// where P[a:b] is the AND of the propagate bits from b to a.
// Assumes: N >= 1; the loops unroll into one AND plane and one OR plane.
module lcg4_sop #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         seed,
    output logic         sop
);
    // Build the OR of every generate term and the seed term.
    always_comb begin
        logic acc;
        acc = seed & (&prop);
        for (int j = 0; j < int'(N); j++) begin
            logic prod;
            prod = gen[j];
            for (int m = j + 1; m < int'(N); m++) begin
                prod = prod & prop[m];
            end
            acc = acc | prod;
        end
        sop = acc;
    end
endmodule

// File: rtl/lcg4_and_all.sv
// Module: lcg4_and_all
// Reduces a vector of propagate bits to the group propagate.
// Assumes: N >= 1.
module lcg4_and_all #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] bits,
    output logic         all_set
);
    // One wide AND over the whole vector.
    always_comb begin
        all_set = &bits;
    end
endmodule

// File: rtl/lcg4_carry_gen.sv
// Module: lcg4_carry_gen (top)
// Resolves the internal carries of a group of GROUP_W positions and
// condenses the group into one generate/propagate pair for a higher level.
// Assumes: purely combinational, with no clock and no reset. The inputs may be
// per-bit or group-level signals.
module lcg4_carry_gen #(
    parameter int unsigned GROUP_W = lcg4_pkg::GROUP_W,
    localparam int unsigned MID_W  = GROUP_W - 1
) (
    input  logic [GROUP_W-1:0] gen_i,
    input  logic [GROUP_W-1:0] prop_i,
    input  logic               carry_i,
    output logic [MID_W-1:0]   carry_mid_o,
    output logic               grp_gen_o,
    output logic               grp_prop_o
);
    // One flat sum of products per internal carry: carry into position k.
    for (genvar k = 1; k < GROUP_W; k++) begin : g_mid
        lcg4_sop #(.N(k)) i_mid_sop (
            .gen  (gen_i[k-1:0]),
            .prop (prop_i[k-1:0]),
            .seed (carry_i),
            .sop  (carry_mid_o[k-1])
        );
    end

    // Group generate: the same product plane over the full group, with no seed.
    lcg4_sop #(.N(GROUP_W)) i_grp_sop (
        .gen  (gen_i),
        .prop (prop_i),
        .seed (1'b0),
        .sop  (grp_gen_o)
    );

    // Group propagate: every position passes a carry through.
    lcg4_and_all #(.N(GROUP_W)) i_grp_and (
        .bits    (prop_i),
        .all_set (grp_prop_o)
    );
endmodule

// File: rtl/lcg4_carry_gen_chk.sv
// Module: lcg4_carry_gen_chk
// Checks the outputs of the top module against each other through the
// ripple relation. It is bound to every instance of lcg4_carry_gen.
// Assumes: combinational evaluation, so it uses immediate assertions only.
module lcg4_carry_gen_chk #(
    parameter int unsigned GROUP_W = 4,
    localparam int unsigned MID_W  = GROUP_W - 1
) (
    input logic [GROUP_W-1:0] gen_i,
    input logic [GROUP_W-1:0] prop_i,
    input logic               carry_i,
    input logic [MID_W-1:0]   carry_mid_o,
    input logic               grp_gen_o,
    input logic               grp_prop_o
);
    // The first carry obeys the generate/kill rule at position 0.
    always_comb begin
        // R1
        first_carry_chk: assert (!gen_i[0] || carry_mid_o[0]);
        // R1
        first_kill_chk: assert (gen_i[0] || prop_i[0] || !carry_mid_o[0]);
    end

    // Each later internal carry follows from the carry below it.
    for (genvar k = 2; k < GROUP_W; k++) begin : g_chain
        always_comb begin
            // R2 R3
            mid_chain_chk: assert (carry_mid_o[k-1] ==
                (gen_i[k-1] | (carry_mid_o[k-2] & prop_i[k-1])));
        end
    end

    // The group pair must rebuild the ripple carry out of the top position.
    always_comb begin
        // R6
        grp_out_chk: assert ((grp_gen_o | (carry_i & grp_prop_o)) ==
            (gen_i[GROUP_W-1] | (carry_mid_o[MID_W-1] & prop_i[GROUP_W-1])));
        // R5
        pass_through_chk: assert (!(grp_prop_o && gen_i == '0) ||
            carry_mid_o == {MID_W{carry_i}});
        // R4
        grp_gen_kill_chk: assert (!(gen_i == '0) || !grp_gen_o);
    end
endmodule

bind lcg4_carry_gen lcg4_carry_gen_chk #(.GROUP_W(GROUP_W)) i_lcg4_carry_gen_chk (
    .gen_i       (gen_i),
    .prop_i      (prop_i),
    .carry_i     (carry_i),
    .carry_mid_o (carry_mid_o),
    .grp_gen_o   (grp_gen_o),
    .grp_prop_o  (grp_prop_o)
);

// File: tb/test_lcg4_carry_gen.sv
// Bench: scoreboard over all 512 input combinations. A driver task applies
// each vector and queues the expected results from a ripple model. A monitor
// compares on the falling edge.
module test_lcg4_carry_gen;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int WDOG_LIMIT = 5000;

    typedef struct {
        logic [W-1:0] g;
        logic [W-1:0] p;
        logic         ci;
        logic [W-2:0] mid;
        logic         gg;
        logic         gp;
        logic         cout;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] gen_i = '0;
    logic [W-1:0] prop_i = '0;
    logic         carry_i = 1'b0;
    logic [W-2:0] carry_mid_o;
    logic         grp_gen_o;
    logic         grp_prop_o;

    int   checks = 0;
    int   failures = 0;
    int   cycles = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    lcg4_carry_gen #(.GROUP_W(W)) i_lcg4_carry_gen (
        .gen_i       (gen_i),
        .prop_i      (prop_i),
        .carry_i     (carry_i),
        .carry_mid_o (carry_mid_o),
        .grp_gen_o   (grp_gen_o),
        .grp_prop_o  (grp_prop_o)
    );

    // Free-running bench clock.
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Compare one value and count the result.
    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s g=%b p=%b ci=%b actual=%b expected=%b",
                     req, gen_i, prop_i, carry_i, act, exp);
        end
    endtask

    // Apply one vector and queue its ripple-model expectation.
    task automatic drive(input logic [W-1:0] g, input logic [W-1:0] p, input logic ci);
        exp_t e;
        logic c;
        @(posedge clk);
        gen_i   <= g;
        prop_i  <= p;
        carry_i <= ci;
        e.g = g; e.p = p; e.ci = ci;
        c = ci;
        for (int k = 0; k < W; k++) begin
            c = g[k] | (c & p[k]);
            if (k < W - 1) e.mid[k] = c;
        end
        e.cout = c;
        c = 1'b0;
        for (int k = 0; k < W; k++) c = g[k] | (c & p[k]);
        e.gg = c;
        e.gp = 1'b1;
        for (int k = 0; k < W; k++) e.gp = e.gp & p[k];
        sb_q.push_back(e);
    endtask

    // Monitor: pop the oldest expectation and compare it on the falling edge.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check("R1", carry_mid_o[0], e.mid[0]);
            check("R2", carry_mid_o[1], e.mid[1]);
            check("R3", carry_mid_o[2], e.mid[2]);
            check("R4", grp_gen_o, e.gg);
            check("R5", grp_prop_o, e.gp);
            check("R6", grp_gen_o | (carry_i & grp_prop_o), e.cout);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > WDOG_LIMIT) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WDOG_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus: reset-state check, then an exhaustive sweep.
    initial begin
        @(negedge clk);
        // R7: all inputs low gives all outputs low, with no state held.
        check("R7", |carry_mid_o, 1'b0);
        check("R7", grp_gen_o, 1'b0);
        check("R7", grp_prop_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: the outputs follow a new input at once, with no clock.
        gen_i = 4'b0001; prop_i = 4'b1110; carry_i = 1'b0;
        #1;
        check("R7", &carry_mid_o, 1'b1);
        check("R7", grp_gen_o, 1'b1);
        gen_i = '0; prop_i = '0;
        for (int v = 0; v < 512; v++) begin
            logic [8:0] bits;
            bits = v[8:0];
            drive(bits[3:0], bits[7:4], bits[8]);
        end
        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule